// File: doc/BRIEF.md
# Component Video Test Pattern Generator

This block produces a stream of 10-bit component video words for full-field test patterns. The words come in Cb, Y, Cr, Y order. Each line opens with an end-of-active-video timing reference. Horizontal blanking follows, then a start-of-active-video timing reference, then the active samples. The block counts its own raster. It supports two line standards: a 525-line frame and a 625-line frame. It also supports two raster widths: a narrow 4:3 raster driven by a 27 MHz word clock and a wide 16:9 raster driven by a 36 MHz word clock.

The pattern comes from a 10-bit select word. Only the low four bits carry a code, and the upper six bits must be zero. There are five patterns:
- flat black;
- an abrupt-edged eight-bar colour pattern at 75% amplitude;
- two serial-link stress fills, one for the cable equalizer and one for the clock recovery loop;
- a check field that shows the equalizer fill in the upper half of each field and the loop fill in the lower half.

A separate two-bit raster select picks the line standard and the aspect ratio. Generation runs while both the enable and the lock inputs are high. The block latches the pattern and the raster choice at the moment generation starts. It also marks the last word of every line and the last word of every field.

All raster dimensions are parameters. A bench can therefore sweep every word of every frame in a reduced raster.

Top module: `vid_pattern_gen`

## Requirements
- R1: While idle or in reset, `vid_valid`, `vid_line_end` and `vid_field_end` are 0 and `vid_data` is 0x000.
- R2: Generation starts once `gen_en` and `pll_locked` are both high. The first word, 0x3FF, appears after the second rising edge at which both are sampled high. The word counter restarts at line 0, word 0. Once either input is sampled low, exactly one more valid word follows, and then `vid_valid` falls. While lock is absent, nothing is produced.
- R3: `raster_sel[0]`=1 selects the 625-line frame and 0 selects the 525-line frame. `raster_sel[1]`=1 selects the wide raster and 0 selects the narrow raster. A line holds HBL+ACT words, using the HBL and ACT parameters for the selected raster. A frame holds LINES lines. Field 1 is the first floor(LINES/2) lines, and field 2 is the rest. The counter wraps from the last line back to line 0.
- R4: Words 0..3 of a line are the end-of-active-video reference, 0x3FF 0x000 0x000 XYZ. Words HBL-4..HBL-1 are the start-of-active-video reference in the same form. The other blanking words are 0x200 at even positions and 0x040 at odd positions. The values 0x000 and 0x3FF appear nowhere else.
- R5: Each XYZ word has bit9=1, bit8=F, bit7=V and bit6=H, where H=1 for end-of-active-video and H=0 for start-of-active-video. The remaining bits are bit5=V^H, bit4=F^H, bit3=F^V, bit2=F^V^H and bits 1..0=0.
- R6: F is 0 in field 1 and 1 in field 2. V is 1 on the first VBL lines of each field. On those lines the active words carry the blanking values of R4.
- R7: Active word a, counted from the first word after the start-of-active-video reference, carries Cb when a mod 4=0, Y when a mod 4 is odd, and Cr when a mod 4=2. Code 0 (black) gives Y=0x040 and Cb=Cr=0x200.
- R8: Code 1 gives eight equal bars of width ACT/8 words, selected by bar index a/(ACT/8). The (Y,Cb,Cr) values in decimal, in bar order, are:
  - 0: (721,512,512)
  - 1: (646,176,567)
  - 2: (525,625,176)
  - 3: (450,289,231)
  - 4: (335,735,793)
  - 5: (260,399,848)
  - 6: (139,848,457)
  - 7: (64,512,512)

  The colour changes at the bar edge with no intermediate values.
- R9: Code 2 (equalizer stress) fills every active word with chroma 0x300 and luma 0x198. Code 3 (loop stress) fills every active word with chroma 0x200 and luma 0x110.
- R10: Code 4 (check field) uses the code 2 values on active line n of a field when n < (field lines − VBL)/2, and the code 3 values otherwise.
- R11: Codes 5..15, and any select word with a nonzero bit in 9..4, produce black.
- R12: `pat_code` and `raster_sel` are latched when generation starts. Changes to them while generation runs have no effect on the output.
- R13: `vid_line_end` is 1 exactly on the last word of each line. `vid_field_end` is 1 exactly on the last word of the last line of each field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_en | input | 1 | Generation request |
| pll_locked | input | 1 | Clock synthesis lock indication |
| pat_code | input | 10 | Pattern select word; code in bits 3..0 |
| raster_sel | input | 2 | Bit 0 line standard, bit 1 aspect ratio |
| vid_valid | output | 1 | Word on `vid_data` is part of the stream |
| vid_data | output | 10 | Video word |
| vid_line_end | output | 1 | Last word of a line |
| vid_field_end | output | 1 | Last word of a field |

## Verification
The assertions assume the raster parameters are legal:
- every blanking width is a multiple of 4 and at least 8;
- every active width is a multiple of 32;
- each field has more lines than VBL.

Under these conditions, the timing references stay aligned to the Cb,Y,Cr,Y cycle and the bars never split a sample group. The assertions also assume the select inputs may change at any time, because latching makes those changes harmless. The bench uses a reduced raster that meets these rules, keeps lock high during each run after an initial lock-absent interval, and scrambles the select inputs in the middle of every run.

// File: rtl/vpg_pkg.sv
package vpg_pkg;

    localparam logic [9:0] W_ONES  = 10'h3FF;
    localparam logic [9:0] W_ZERO  = 10'h000;
    localparam logic [9:0] BLANK_C = 10'h200;
    localparam logic [9:0] BLANK_Y = 10'h040;
    localparam logic [9:0] EQS_C   = 10'h300;
    localparam logic [9:0] EQS_Y   = 10'h198;
    localparam logic [9:0] LPS_C   = 10'h200;
    localparam logic [9:0] LPS_Y   = 10'h110;

    typedef enum logic [2:0] {
        PAT_BLACK = 3'd0,
        PAT_BARS  = 3'd1,
        PAT_EQS   = 3'd2,
        PAT_LPS   = 3'd3,
        PAT_CHECK = 3'd4
    } pat_e;

    typedef struct packed {
        logic       is_trs;
        logic [1:0] trs_idx;
        logic       is_eav;
        logic       in_act;
        logic [1:0] phase;
        logic [2:0] bar;
        logic       fld;
        logic       vbl;
        logic       upper;
        logic       line_last;
        logic       field_last;
    } pos_t;

    typedef struct packed {
        logic       valid;
        logic [9:0] data;
        logic       line_end;
        logic       field_end;
    } vid_word_t;

    function automatic pat_e decode_sel(input logic [9:0] s);
        pat_e p;
        if (s[9:4] != 6'd0) begin
            p = PAT_BLACK;
        end else begin
            case (s[3:0])
                4'd1:    p = PAT_BARS;
                4'd2:    p = PAT_EQS;
                4'd3:    p = PAT_LPS;
                4'd4:    p = PAT_CHECK;
                default: p = PAT_BLACK;
            endcase
        end
        return p;
    endfunction

    // phase 0 = Cb, 2 = Cr, odd = Y
    function automatic logic [9:0] bar_word(input logic [2:0] idx, input logic [1:0] ph);
        logic [9:0] y, cb, cr;
        case (idx)
            3'd0: begin y = 10'd721; cb = 10'd512; cr = 10'd512; end
            3'd1: begin y = 10'd646; cb = 10'd176; cr = 10'd567; end
            3'd2: begin y = 10'd525; cb = 10'd625; cr = 10'd176; end
            3'd3: begin y = 10'd450; cb = 10'd289; cr = 10'd231; end
            3'd4: begin y = 10'd335; cb = 10'd735; cr = 10'd793; end
            3'd5: begin y = 10'd260; cb = 10'd399; cr = 10'd848; end
            3'd6: begin y = 10'd139; cb = 10'd848; cr = 10'd457; end
            default: begin y = 10'd64; cb = 10'd512; cr = 10'd512; end
        endcase
        if (ph[0])
            return y;
        else if (ph[1])
            return cr;
        else
            return cb;
    endfunction

    function automatic logic [9:0] xyz_word(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
    endfunction

endpackage

// File: rtl/vpg_raster.sv
module vpg_raster #(
    parameter int HTOT_N525 = 1716,
    parameter int HTOT_N625 = 1728,
    parameter int HTOT_W525 = 2288,
    parameter int HTOT_W625 = 2304,
    parameter int LINES_525 = 525,
    parameter int LINES_625 = 625,
    parameter int HW        = 12,
    parameter int LW        = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go_i,
    input  logic [9:0]          sel_i,
    input  logic [1:0]          fmt_i,
    output logic                running_o,
    output vpg_pkg::pat_e       pat_o,
    output logic                wide_o,
    output logic                is625_o,
    output logic [HW-1:0]       h_o,
    output logic [LW-1:0]       ln_o
);
    import vpg_pkg::*;

    typedef struct packed {
        logic          running;
        pat_e          pat;
        logic          wide;
        logic          is625;
        logic [HW-1:0] h;
        logic [LW-1:0] ln;
    } rstate_t;

    rstate_t st_d, st_q;
    int      htot_cur;
    int      nl_cur;

    always_comb begin
        if (st_q.wide)
            htot_cur = st_q.is625 ? HTOT_W625 : HTOT_W525;
        else
            htot_cur = st_q.is625 ? HTOT_N625 : HTOT_N525;
        nl_cur = st_q.is625 ? LINES_625 : LINES_525;
    end

    always_comb begin
        st_d = st_q;
        if (!st_q.running) begin
            if (go_i) begin
                st_d.running = 1'b1;
                st_d.pat     = decode_sel(sel_i);
                st_d.wide    = fmt_i[1];
                st_d.is625   = fmt_i[0];
                st_d.h       = '0;
                st_d.ln      = '0;
            end
        end else if (!go_i) begin
            st_d.running = 1'b0;
            st_d.h       = '0;
            st_d.ln      = '0;
        end else if (int'(st_q.h) == htot_cur - 1) begin
            st_d.h = '0;
            if (int'(st_q.ln) == nl_cur - 1)
                st_d.ln = '0;
            else
                st_d.ln = st_q.ln + LW'(1);
        end else begin
            st_d.h = st_q.h + HW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign running_o = st_q.running;
    assign pat_o     = st_q.pat;
    assign wide_o    = st_q.wide;
    assign is625_o   = st_q.is625;
    assign h_o       = st_q.h;
    assign ln_o      = st_q.ln;

    p_hwrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.running && int'(st_q.h) == htot_cur - 1 |=> !st_q.running || st_q.h == '0);

    p_hstep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.running && int'(st_q.h) != htot_cur - 1 |=> !st_q.running || st_q.h == $past(st_q.h) + HW'(1));

    p_latch_r12: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.running && $past(st_q.running) |-> $stable(st_q.pat) && $stable(st_q.wide) && $stable(st_q.is625));

    p_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.running) |-> st_q.h == '0 && st_q.ln == '0);

endmodule

// File: rtl/vpg_decode.sv
module vpg_decode #(
    parameter int ACT_43      = 1440,
    parameter int ACT_169     = 1920,
    parameter int HBL_525_43  = 276,
    parameter int HBL_625_43  = 288,
    parameter int HBL_525_169 = 368,
    parameter int HBL_625_169 = 384,
    parameter int LINES_525   = 525,
    parameter int LINES_625   = 625,
    parameter int VBL_525     = 20,
    parameter int VBL_625     = 24,
    parameter int HW          = 12,
    parameter int LW          = 10
) (
    input  logic           wide_i,
    input  logic           is625_i,
    input  logic [HW-1:0]  h_i,
    input  logic [LW-1:0]  ln_i,
    output vpg_pkg::pos_t  pos_o
);
    import vpg_pkg::*;

    localparam int BW_43  = ACT_43 / 8;
    localparam int BW_169 = ACT_169 / 8;

    always_comb begin
        int hi, li, hb, act, htot, nl, vb, f1, loc, flen, ai, off;
        hi   = int'(h_i);
        li   = int'(ln_i);
        if (wide_i)
            hb = is625_i ? HBL_625_169 : HBL_525_169;
        else
            hb = is625_i ? HBL_625_43 : HBL_525_43;
        act  = wide_i ? ACT_169 : ACT_43;
        htot = hb + act;
        nl   = is625_i ? LINES_625 : LINES_525;
        vb   = is625_i ? VBL_625 : VBL_525;
        f1   = nl / 2;

        pos_o       = '0;
        pos_o.phase = 2'(hi);
        off         = 0;
        if (hi < 4) begin
            pos_o.is_trs  = 1'b1;
            pos_o.is_eav  = 1'b1;
            pos_o.trs_idx = 2'(hi);
        end else if (hi >= hb - 4 && hi < hb) begin
            pos_o.is_trs  = 1'b1;
            pos_o.trs_idx = 2'(hi - hb + 4);
        end else if (hi >= hb) begin
            pos_o.in_act = 1'b1;
            off          = hi - hb;
            pos_o.bar    = 3'(wide_i ? off / BW_169 : off / BW_43);
        end

        pos_o.fld   = (li >= f1);
        loc         = pos_o.fld ? li - f1 : li;
        flen        = pos_o.fld ? nl - f1 : f1;
        pos_o.vbl   = (loc < vb);
        ai          = loc - vb;
        pos_o.upper = (ai < (flen - vb) / 2);

        pos_o.line_last  = (hi == htot - 1);
        pos_o.field_last = pos_o.line_last && (li == f1 - 1 || li == nl - 1);
    end

endmodule

// File: rtl/vpg_sample.sv
module vpg_sample (
    input  vpg_pkg::pat_e  pat_i,
    input  vpg_pkg::pos_t  pos_i,
    output logic [9:0]     word_o
);
    import vpg_pkg::*;

    always_comb begin
        logic is_c;
        is_c = ~pos_i.phase[0];
        if (pos_i.is_trs) begin
            case (pos_i.trs_idx)
                2'd0:    word_o = W_ONES;
                2'd3:    word_o = xyz_word(pos_i.fld, pos_i.vbl, pos_i.is_eav);
                default: word_o = W_ZERO;
            endcase
        end else if (!pos_i.in_act || pos_i.vbl) begin
            word_o = is_c ? BLANK_C : BLANK_Y;
        end else begin
            case (pat_i)
                PAT_BARS:  word_o = bar_word(pos_i.bar, pos_i.phase);
                PAT_EQS:   word_o = is_c ? EQS_C : EQS_Y;
                PAT_LPS:   word_o = is_c ? LPS_C : LPS_Y;
                PAT_CHECK: begin
                    if (pos_i.upper)
                        word_o = is_c ? EQS_C : EQS_Y;
                    else
                        word_o = is_c ? LPS_C : LPS_Y;
                end
                default:   word_o = is_c ? BLANK_C : BLANK_Y;
            endcase
        end
    end

    always_comb begin
        if (!pos_i.is_trs) begin
            p_excl_codes_r4: assert (word_o != W_ONES && word_o != W_ZERO);
        end
    end

endmodule

// File: rtl/vid_pattern_gen.sv
module vid_pattern_gen #(
    parameter int ACT_43      = 1440,
    parameter int ACT_169     = 1920,
    parameter int HBL_525_43  = 276,
    parameter int HBL_625_43  = 288,
    parameter int HBL_525_169 = 368,
    parameter int HBL_625_169 = 384,
    parameter int LINES_525   = 525,
    parameter int LINES_625   = 625,
    parameter int VBL_525     = 20,
    parameter int VBL_625     = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gen_en,
    input  logic       pll_locked,
    input  logic [9:0] pat_code,
    input  logic [1:0] raster_sel,
    output logic       vid_valid,
    output logic [9:0] vid_data,
    output logic       vid_line_end,
    output logic       vid_field_end
);
    import vpg_pkg::*;

    localparam int HTOT_N525 = HBL_525_43 + ACT_43;
    localparam int HTOT_N625 = HBL_625_43 + ACT_43;
    localparam int HTOT_W525 = HBL_525_169 + ACT_169;
    localparam int HTOT_W625 = HBL_625_169 + ACT_169;
    localparam int HMAX_N    = (HTOT_N525 > HTOT_N625) ? HTOT_N525 : HTOT_N625;
    localparam int HMAX_W    = (HTOT_W525 > HTOT_W625) ? HTOT_W525 : HTOT_W625;
    localparam int HTOT_MAX  = (HMAX_N > HMAX_W) ? HMAX_N : HMAX_W;
    localparam int LINES_MAX = (LINES_525 > LINES_625) ? LINES_525 : LINES_625;
    localparam int HW        = $clog2(HTOT_MAX);
    localparam int LW        = $clog2(LINES_MAX);

    logic          running;
    pat_e          pat;
    logic          wide;
    logic          is625;
    logic [HW-1:0] hpos;
    logic [LW-1:0] lpos;
    pos_t          pos;
    logic [9:0]    word;
    vid_word_t     out_d, out_q;

    vpg_raster #(
        .HTOT_N525(HTOT_N525), .HTOT_N625(HTOT_N625),
        .HTOT_W525(HTOT_W525), .HTOT_W625(HTOT_W625),
        .LINES_525(LINES_525), .LINES_625(LINES_625),
        .HW(HW), .LW(LW)
    ) u_raster (
        .clk(clk), .rst_n(rst_n), .go_i(gen_en && pll_locked),
        .sel_i(pat_code), .fmt_i(raster_sel),
        .running_o(running), .pat_o(pat), .wide_o(wide), .is625_o(is625),
        .h_o(hpos), .ln_o(lpos)
    );

    vpg_decode #(
        .ACT_43(ACT_43), .ACT_169(ACT_169),
        .HBL_525_43(HBL_525_43), .HBL_625_43(HBL_625_43),
        .HBL_525_169(HBL_525_169), .HBL_625_169(HBL_625_169),
        .LINES_525(LINES_525), .LINES_625(LINES_625),
        .VBL_525(VBL_525), .VBL_625(VBL_625),
        .HW(HW), .LW(LW)
    ) u_decode (
        .wide_i(wide), .is625_i(is625), .h_i(hpos), .ln_i(lpos), .pos_o(pos)
    );

    vpg_sample u_sample (
        .pat_i(pat), .pos_i(pos), .word_o(word)
    );

    always_comb begin
        out_d = '0;
        if (running) begin
            out_d.valid     = 1'b1;
            out_d.data      = word;
            out_d.line_end  = pos.line_last;
            out_d.field_end = pos.field_last;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    assign vid_valid     = out_q.valid;
    assign vid_data      = out_q.data;
    assign vid_line_end  = out_q.line_end;
    assign vid_field_end = out_q.field_end;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_valid |-> vid_data == 10'h000 && !vid_line_end && !vid_field_end);

    p_start_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vid_valid) |-> vid_data == 10'h3FF);

    p_eav_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vid_valid && vid_line_end |=> !vid_valid || vid_data == 10'h3FF);

    p_xyz_prot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vid_valid && $past(vid_valid, 1) && $past(vid_valid, 2) && $past(vid_valid, 3)
        && $past(vid_data, 3) == 10'h3FF && $past(vid_data, 2) == 10'h000
        && $past(vid_data, 1) == 10'h000
        |-> vid_data[9] && vid_data[1:0] == 2'b00
            && vid_data[5] == (vid_data[7] ^ vid_data[6])
            && vid_data[4] == (vid_data[8] ^ vid_data[6])
            && vid_data[3] == (vid_data[8] ^ vid_data[7])
            && vid_data[2] == (vid_data[8] ^ vid_data[7] ^ vid_data[6]));

    p_field_in_line_r13: assert property (@(posedge clk) disable iff (!rst_n)
        vid_field_end |-> vid_line_end);

endmodule

// File: tb/vid_pattern_gen_test.sv
module vid_pattern_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int A43 = 96, A169 = 128;
    localparam int HB_N525 = 12, HB_N625 = 16, HB_W525 = 20, HB_W625 = 24;
    localparam int L525 = 9, L625 = 11, V525 = 2, V625 = 3;
    localparam int WD_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gen_en = 1'b0;
    logic       pll_locked = 1'b0;
    logic [9:0] pat_code = '0;
    logic [1:0] raster_sel = '0;
    logic       vid_valid, vid_line_end, vid_field_end;
    logic [9:0] vid_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vid_pattern_gen #(
        .ACT_43(A43), .ACT_169(A169),
        .HBL_525_43(HB_N525), .HBL_625_43(HB_N625),
        .HBL_525_169(HB_W525), .HBL_625_169(HB_W625),
        .LINES_525(L525), .LINES_625(L625),
        .VBL_525(V525), .VBL_625(V625)
    ) uut (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .pll_locked(pll_locked),
        .pat_code(pat_code), .raster_sel(raster_sel),
        .vid_valid(vid_valid), .vid_data(vid_data),
        .vid_line_end(vid_line_end), .vid_field_end(vid_field_end)
    );

    int bar_y [8] = '{721, 646, 525, 450, 335, 260, 139, 64};
    int bar_cb[8] = '{512, 176, 625, 289, 735, 399, 848, 512};
    int bar_cr[8] = '{512, 567, 176, 231, 793, 848, 457, 512};

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int htot_of(input int fm);
        int hb, act;
        hb  = (fm == 0) ? HB_N525 : (fm == 1) ? HB_N625 : (fm == 2) ? HB_W525 : HB_W625;
        act = (fm >= 2) ? A169 : A43;
        return hb + act;
    endfunction

    // Expected word at stream index k; tag names the requirement it exercises
    task automatic model(input int fm, input int code, input int k,
                         output int w, output int le, output int fe, output string tag);
        int hb, act, htot, nl, vb, h, ln, f1, f, loc, flen, v, a, ph, pat, ai, idx, hh, c, y;
        hb   = (fm == 0) ? HB_N525 : (fm == 1) ? HB_N625 : (fm == 2) ? HB_W525 : HB_W625;
        act  = (fm >= 2) ? A169 : A43;
        htot = hb + act;
        nl   = (fm % 2 == 1) ? L625 : L525;
        vb   = (fm % 2 == 1) ? V625 : V525;
        h    = k % htot;
        ln   = (k / htot) % nl;
        f1   = nl / 2;
        f    = (ln >= f1) ? 1 : 0;
        loc  = f ? ln - f1 : ln;
        flen = f ? nl - f1 : f1;
        v    = (loc < vb) ? 1 : 0;
        le   = (h == htot - 1) ? 1 : 0;
        fe   = (le == 1 && (ln == f1 - 1 || ln == nl - 1)) ? 1 : 0;
        pat  = (code >= 0 && code <= 4) ? code : 0;
        if (h < 4 || (h >= hb - 4 && h < hb)) begin
            idx = (h < 4) ? h : h - hb + 4;
            hh  = (h < 4) ? 1 : 0;
            if (idx == 0) w = 'h3FF;
            else if (idx < 3) w = 0;
            else w = 512 + f * 256 + v * 128 + hh * 64 + (v ^ hh) * 32
                     + (f ^ hh) * 16 + (f ^ v) * 8 + (f ^ v ^ hh) * 4;
            tag = "R5";
        end else if (h < hb) begin
            w = (h % 2 == 0) ? 'h200 : 'h040;
            tag = "R4";
        end else begin
            a  = h - hb;
            ph = a % 4;
            ai = loc - vb;
            if (v == 1) begin
                w = (ph % 2 == 0) ? 'h200 : 'h040;
                tag = "R6";
            end else begin
                if (pat == 4) pat = (ai < (flen - vb) / 2) ? 2 : 3;
                case (pat)
                    1: begin
                        idx = a / (act / 8);
                        w = (ph % 2 == 1) ? bar_y[idx] : (ph == 0) ? bar_cb[idx] : bar_cr[idx];
                        tag = "R8";
                    end
                    2: begin c = 'h300; y = 'h198; w = (ph % 2 == 0) ? c : y; tag = "R9"; end
                    3: begin c = 'h200; y = 'h110; w = (ph % 2 == 0) ? c : y; tag = "R9"; end
                    default: begin w = (ph % 2 == 0) ? 'h200 : 'h040; tag = "R7"; end
                endcase
                if (code == 4) tag = "R10";
            end
        end
        if (code < 0 || code > 4) tag = "R11";
    endtask

    task automatic run(input int fm, input int code_word);
        int n, w, le, fe, code;
        string tag;
        code = (code_word > 15) ? -1 : code_word;
        n = htot_of(fm) * ((fm % 2 == 1) ? L625 : L525) + htot_of(fm);
        @(negedge clk);
        pat_code   = 10'(code_word);
        raster_sel = 2'(fm);
        gen_en     = 1'b1;
        pll_locked = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R2 no output without lock", int'(vid_valid), 0);
        end
        pll_locked = 1'b1;
        @(negedge clk);
        check("R2 first edge still idle", int'(vid_valid), 0);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            model(fm, code, k, w, le, fe, tag);
            if (k > 8) tag = {tag, " R12"};
            if (k == 0) tag = {tag, " R2"};
            check(tag, int'(vid_valid), 1);
            check(tag, int'(vid_data), w);
            check("R3 R13 line_end", int'(vid_line_end), le);
            check("R3 R13 field_end", int'(vid_field_end), fe);
            if (k == 8) begin
                pat_code   = ~pat_code;
                raster_sel = ~raster_sel;
            end
        end
        gen_en = 1'b0;
        @(negedge clk);
        model(fm, code, n, w, le, fe, tag);
        check("R2 one word after stop", int'(vid_valid), 1);
        check("R2 word after stop", int'(vid_data), w);
        @(negedge clk);
        check("R2 valid falls", int'(vid_valid), 0);
        check("R1 idle data", int'(vid_data), 0);
        check("R1 idle flags", int'(vid_line_end | vid_field_end), 0);
        pll_locked = 1'b0;
    endtask

    initial begin
        int codes[8] = '{0, 1, 2, 3, 4, 5, 15, 'h011};
        repeat (3) @(negedge clk);
        gen_en = 1'b1;
        pll_locked = 1'b1;
        @(negedge clk);
        check("R1 reset valid", int'(vid_valid), 0);
        check("R1 reset data", int'(vid_data), 0);
        check("R1 reset flags", int'(vid_line_end | vid_field_end), 0);
        gen_en = 1'b0;
        pll_locked = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", int'(vid_valid), 0);
        for (int fm = 0; fm < 4; fm++)
            for (int ci = 0; ci < 8; ci++)
                run(fm, codes[ci]);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=0", WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule